// File: doc/BRIEF.md
# Filtered Port Pin Interrupt Detector

This block watches a group of general-purpose input pins and raises a per-pin interrupt flag when a pin makes a clean, qualified transition of the chosen direction. Every pin passes through a two-flop synchroniser and then a digital glitch filter. The filter counts consecutive samples taken at the same level. A transition qualifies only after the pin has rested at its idle level for `QUAL` samples and then held the opposite level for `QUAL` samples. Short spikes are therefore rejected, and the pin needs no analogue filtering.

In normal operation the filter takes a sample on every clock. In stop mode it samples only when a pulse arrives on `slow_tick`, which comes from a slow low-power oscillator outside this block. The block tells the system whether that oscillator is needed through `clk_req_o`. The request is high while some enabled pin that has no pending flag still has filter work to do. Software sets the enable and polarity bits through a small write port and clears flags by writing ones. The combined interrupt output is high whenever an enabled pin has its flag set.

Top module: `port_irq_filter`

## Requirements
- R1: After reset the enable, polarity and flag registers are all zero, and `irq_o` and `clk_req_o` are low.
- R2: A transition qualifies only when `QUAL` (default 4) consecutive samples at the idle level come before the active run. With only `QUAL-1` idle samples the flag stays clear. In run mode the flag becomes visible after the 6th rising clock edge that follows the pin change: two synchroniser stages plus four samples.
- R3: An active excursion lasting `QUAL-1` samples or fewer never sets the flag.
- R4: An active excursion lasting `QUAL` samples or more, after qualification at the idle level, sets the pin's flag.
- R5: A polarity bit of 1 selects rising edges (idle low, active high). A polarity bit of 0 selects falling edges (idle high, active low).
- R6: Once the idle qualification is reached, it stays armed across short active glitches until a full active run of `QUAL` samples completes, and that run then sets the flag.
- R7: Writing with `wr_sel`=2 clears each flag whose `wr_data` bit is 1. A qualified edge in the same cycle wins, so the flag stays set.
- R8: While a pin's enable bit is 0, its flag is not set, but its filter keeps counting.
- R9: `irq_o` is the OR over all pins of flag AND enable.
- R10: With `stop_mode`=0 the filter advances every clock. With `stop_mode`=1 it advances only in cycles where `slow_tick`=1, and it holds its state otherwise.
- R11: `clk_req_o` is high when at least one pin has enable 1 and flag 0, and either its run count is at most `QUAL` or its synchronised level differs from the last filtered level.
- R12: A write with `wr_sel`=0 loads the enable bits and a write with `wr_sel`=1 loads the polarity bits. `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_mode | input | 1 | 1: filters advance only on `slow_tick` |
| slow_tick | input | 1 | One-cycle pulse from the stop-mode sampling oscillator |
| pin_in | input | NPINS | Raw pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 enable, 1 polarity, 2 flag clear, 3 none |
| wr_data | input | NPINS | Write data, one bit per pin |
| ien_o | output | NPINS | Enable register |
| pol_o | output | NPINS | Polarity register |
| flag_o | output | NPINS | Interrupt flags |
| irq_o | output | 1 | Combined interrupt request |
| clk_req_o | output | 1 | Filter sampling clock needed |

## Verification
The bench uses the default parameters, `NPINS`=8 and `QUAL`=4. This configuration is small enough to sweep every pin, both polarities and every pulse width from 1 to 6 samples, and to compare the full flag vector each time. That sweep covers both sides of the four-sample threshold on every pin. Because `QUAL` is small, directed sequences can also hit each exact boundary: 3 against 4 idle samples, the cycle-exact flag latency, a clear that coincides with an edge, and tick-by-tick stepping in stop mode.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
    typedef enum logic [1:0] {
        SEL_ENABLE   = 2'd0,
        SEL_POLARITY = 2'd1,
        SEL_CLEAR    = 2'd2,
        SEL_NONE     = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2 == $past(st_q.s1));
endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter #(
    parameter int QUAL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic lvl_i,
    input  logic pol_i,
    output logic edge_o,
    output logic busy_o
);
    localparam int CNT_W = $clog2(QUAL + 2);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(QUAL + 1);
    localparam logic [CNT_W-1:0] QV  = CNT_W'(QUAL);

    typedef struct packed {
        logic             last;
        logic [CNT_W-1:0] run;
        logic             armed;
    } filt_t;

    filt_t st_d, st_q;
    logic active;
    logic [CNT_W-1:0] nrun;

    always_comb begin
        st_d   = st_q;
        edge_o = 1'b0;
        active = pol_i ? lvl_i : ~lvl_i;
        nrun   = '0;
        if (adv_i) begin
            if (lvl_i == st_q.last)
                nrun = (st_q.run == SAT) ? SAT : st_q.run + 1'b1;
            else
                nrun = CNT_W'(1);
            st_d.last = lvl_i;
            st_d.run  = nrun;
            if (!active && nrun >= QV)
                st_d.armed = 1'b1;
            if (active && st_q.armed && nrun == QV) begin
                edge_o     = 1'b1;
                st_d.armed = 1'b0;
            end
        end
        busy_o = (st_q.run <= QV) || (lvl_i != st_q.last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(st_q));
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= SAT);
    // R6
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !st_q.armed);
endmodule

// File: rtl/port_irq_filter.sv
module port_irq_filter
    import port_irq_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int QUAL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_mode,
    input  logic             slow_tick,
    input  logic [NPINS-1:0] pin_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] ien_o,
    output logic [NPINS-1:0] pol_o,
    output logic [NPINS-1:0] flag_o,
    output logic             irq_o,
    output logic             clk_req_o
);
    typedef struct packed {
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] flag;
    } regs_t;

    regs_t st_d, st_q;
    logic [NPINS-1:0] lvl, edge_v, busy_v;
    logic adv;

    assign adv = stop_mode ? slow_tick : 1'b1;

    pin_sync #(.W(NPINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (lvl)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_edge_filter #(.QUAL(QUAL)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (adv),
            .lvl_i  (lvl[i]),
            .pol_i  (st_q.pol[i]),
            .edge_o (edge_v[i]),
            .busy_o (busy_v[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_ENABLE:   st_d.ien  = wr_data;
                SEL_POLARITY: st_d.pol  = wr_data;
                SEL_CLEAR:    st_d.flag = st_q.flag & ~wr_data;
                default:      ;
            endcase
        end
        st_d.flag = st_d.flag | (edge_v & st_q.ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien_o     = st_q.ien;
    assign pol_o     = st_q.pol;
    assign flag_o    = st_q.flag;
    assign irq_o     = |(st_q.flag & st_q.ien);
    assign clk_req_o = |(busy_v & st_q.ien & ~st_q.flag);

    // R7
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q.flag) & ~st_q.flag) != '0) |-> $past(wr_en && wr_sel == SEL_CLEAR));
    // R8
    flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag & ~$past(st_q.flag) & ~$past(st_q.ien)) == '0);
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q.flag != '0));
endmodule

// File: tb/port_irq_filter_tb.sv
module port_irq_filter_tb_top;
    localparam int NP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_mode = 1'b0;
    logic slow_tick = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [NP-1:0] wr_data = '0;
    logic [NP-1:0] ien_o, pol_o, flag_o;
    logic irq_o, clk_req_o;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    port_irq_filter #(.NPINS(NP), .QUAL(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .slow_tick(slow_tick),
        .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ien_o(ien_o), .pol_o(pol_o), .flag_o(flag_o), .irq_o(irq_o),
        .clk_req_o(clk_req_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [NP-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step(1);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic tick();
        slow_tick = 1'b1;
        step(1);
        slow_tick = 1'b0;
        step(2);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 ien", 32'(ien_o), 0);
        chk("R1 pol", 32'(pol_o), 0);
        chk("R1 flag", 32'(flag_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 clk_req", 32'(clk_req_o), 0);

        // R12 register writes
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hA5);
        chk("R12 ien load", 32'(ien_o), 32'hFF);
        chk("R12 pol load", 32'(pol_o), 32'hA5);
        wr(2'd3, 8'h00);
        chk("R12 sel3 ien", 32'(ien_o), 32'hFF);
        chk("R12 sel3 pol", 32'(pol_o), 32'hA5);

        // R3 R4 R5 R9 sweep: polarity x pin x width
        for (int pv = 0; pv < 2; pv++) begin
            logic pl;
            pl = pv[0];
            wr(2'd1, {NP{pl}});
            pin_in = {NP{~pl}};
            step(12);
            wr(2'd2, 8'hFF);
            for (int p = 0; p < NP; p++) begin
                for (int w = 1; w <= 6; w++) begin
                    logic [NP-1:0] exp;
                    pin_in = {NP{~pl}};
                    step(8);
                    pin_in[p] = pl;
                    step(w);
                    pin_in[p] = ~pl;
                    step(10);
                    exp = (w >= 4) ? NP'(1) << p : '0;
                    chk(w >= 4 ? "R4/R5 long pulse flag" : "R3/R5 short pulse flag",
                        32'(flag_o), 32'(exp));
                    chk("R9 irq", 32'(irq_o), 32'(w >= 4));
                    wr(2'd2, 8'hFF);
                end
            end
        end

        // rising edges on all pins from here
        wr(2'd1, 8'hFF);
        pin_in = '0;
        step(12);
        wr(2'd2, 8'hFF);

        // R2 exact latency
        pin_in[0] = 1'b1;
        step(5);
        chk("R2 flag before 6th edge", 32'(flag_o[0]), 0);
        step(1);
        chk("R2 flag after 6th edge", 32'(flag_o[0]), 1);
        step(10);
        wr(2'd2, 8'hFF);

        // R2 three idle samples do not qualify
        pin_in[0] = 1'b0;
        step(3);
        pin_in[0] = 1'b1;
        step(12);
        chk("R2 three idle samples", 32'(flag_o[0]), 0);
        // R2 four idle samples qualify
        pin_in[0] = 1'b0;
        step(4);
        pin_in[0] = 1'b1;
        step(12);
        chk("R2 four idle samples", 32'(flag_o[0]), 1);
        wr(2'd2, 8'hFF);

        // R6 armed across glitch
        pin_in[0] = 1'b0; step(8);
        pin_in[0] = 1'b1; step(2);
        pin_in[0] = 1'b0; step(1);
        pin_in[0] = 1'b1; step(4);
        pin_in[0] = 1'b0; step(8);
        chk("R6 indirect qualification", 32'(flag_o[0]), 1);

        // R7 clear coinciding with new edge: set wins
        pin_in[0] = 1'b1;
        step(5);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h01;
        step(1);
        wr_en = 1'b0; wr_sel = 2'd3;
        chk("R7 set beats clear", 32'(flag_o[0]), 1);
        wr(2'd2, 8'h01);
        chk("R7 write-one clear", 32'(flag_o[0]), 0);

        // R8 disabled pin: no flag, filter keeps counting
        wr(2'd0, 8'hFE);
        pin_in[0] = 1'b0; step(8);
        pin_in[0] = 1'b1; step(8);
        chk("R8 disabled no flag", 32'(flag_o), 0);
        chk("R11 disabled no req", 32'(clk_req_o), 0);
        pin_in[0] = 1'b0; step(6);
        wr(2'd0, 8'h01);
        pin_in[0] = 1'b1; step(8);
        chk("R8 filter kept running", 32'(flag_o), 1);
        // R9 irq masked by enable
        chk("R9 irq enabled", 32'(irq_o), 1);
        wr(2'd0, 8'h00);
        chk("R9 irq masked", 32'(irq_o), 0);
        chk("R9 flag retained", 32'(flag_o), 1);
        wr(2'd2, 8'hFF);

        // R11 clock request in run mode
        wr(2'd0, 8'h01);
        pin_in[0] = 1'b0; step(10);
        chk("R11 settled no req", 32'(clk_req_o), 0);
        pin_in[0] = 1'b1; step(3);
        chk("R11 counting req", 32'(clk_req_o), 1);
        step(5);
        chk("R11 flag blocks req", 32'(clk_req_o), 0);
        wr(2'd2, 8'hFF);

        // R10 stop mode stepping
        pin_in[0] = 1'b0; step(10);
        stop_mode = 1'b1;
        pin_in[0] = 1'b1;
        step(20);
        chk("R10 frozen without tick", 32'(flag_o[0]), 0);
        chk("R11 req pending level change", 32'(clk_req_o), 1);
        tick(); tick(); tick();
        chk("R10 three ticks", 32'(flag_o[0]), 0);
        step(10);
        chk("R10 still frozen", 32'(flag_o[0]), 0);
        tick();
        chk("R10 fourth tick", 32'(flag_o[0]), 1);
        chk("R11 stop req off", 32'(clk_req_o), 0);
        stop_mode = 1'b0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule